// File: doc/BRIEF.md
# Write-Once Programming Clock Divider

This block holds the timing setup for nonvolatile-memory erase and program operations. Its one bus register carries three fields. A single prescale bit chooses whether the bus clock is first divided by eight. A 6-bit divisor then divides that rate by the divisor plus one. Both fields accept only the first write after reset. That first write also raises a read-only "loaded" flag, whatever data it carries.

The division is a clock enable, not a derived clock. The block produces a `tick` that is high for exactly one bus cycle, once per divided period. The erase/program sequencer uses `tick` as its timing pulse. Until the loaded flag is set, both counters are held at zero and `tick` stays low. This keeps erase and program operations disabled until software has set the clock up. Once the flag is set, the counters start from zero in the cycle that follows the setting write.

Top module: `prog_tick_div`

## Requirements
- R1: A read returns the loaded flag in bit 7, the prescale select in bit 6 and the divisor in bits 5:0.
- R2: Reset clears the loaded flag. The first write sets it whatever the data value, and bit 7 of the write data has no effect on it.
- R3: While the loaded flag is 0, `tick` stays low.
- R4: The prescale select and the divisor take their values from the first write only. Any later write leaves them, and the tick period, unchanged.
- R5: With prescale select 0 and divisor D, `tick` repeats every D+1 bus cycles. D=0 gives a tick on every cycle.
- R6: With prescale select 1 and divisor D, `tick` repeats every 8*(D+1) bus cycles.
- R7: Each `tick` lasts exactly one bus cycle whenever the period is longer than one cycle.
- R8: Both counters start from zero at the first write. With period P, the first tick appears in the P-th cycle after the clock edge that accepts that write, counting the cycle right after that edge as the first.
- R9: After reset the read data is all zeros and `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data: bit 6 prescale select, bits 5:0 divisor |
| rd_data | output | 8 | Register read value |
| loaded | output | 1 | Loaded flag, enables erase/program timing |
| tick | output | 1 | One-cycle erase/program timing enable |

## Verification
The assertions assume three things about the inputs. `wr_en` is a synchronous strobe with known values. Reset is held over at least one clock edge. No other agent changes the register between reset and the first write. The stimulus meets these conditions in the following way. It changes `wr_en` and `wr_data` only on the falling edge and pulses `wr_en` for a single cycle. It applies a full reset before every new setting, so each first write arrives with the flag clear.

// File: rtl/prog_tick_div.sv
module prog_tick_div #(
  parameter int DIV_W    = 6,
  parameter int PRE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  output logic [DIV_W+1:0] rd_data,
  output logic             loaded,
  output logic             tick
);
  localparam logic [PRE_LOG2-1:0] PRE_ONE = 1;
  localparam logic [DIV_W-1:0]    DIV_ONE = 1;

  logic                loaded_q, pre_sel_q;
  logic [DIV_W-1:0]    div_q, div_cnt;
  logic [PRE_LOG2-1:0] pre_cnt;
  logic                pre_wrap, div_wrap;

  assign pre_wrap = pre_sel_q ? &pre_cnt : 1'b1;
  assign div_wrap = (div_cnt == div_q);
  assign tick     = loaded_q & pre_wrap & div_wrap;
  assign loaded   = loaded_q;
  assign rd_data  = {loaded_q, pre_sel_q, div_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      pre_sel_q <= 1'b0;
      div_q     <= '0;
      pre_cnt   <= '0;
      div_cnt   <= '0;
    end else begin
      if (wr_en) loaded_q <= 1'b1;
      if (wr_en && !loaded_q) begin
        pre_sel_q <= wr_data[DIV_W];
        div_q     <= wr_data[DIV_W-1:0];
      end
      if (!loaded_q) begin
        pre_cnt <= '0;
        div_cnt <= '0;
      end else begin
        pre_cnt <= pre_cnt + PRE_ONE;
        if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + DIV_ONE;
      end
    end
  end
endmodule

// File: rtl/prog_tick_div_chk.sv
module prog_tick_div_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W+1:0] rd_data,
  input logic             loaded,
  input logic             tick
);
  p_no_tick_unloaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick);
  p_write_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> loaded);
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  p_settings_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> $stable(rd_data[DIV_W:0]));
  p_flag_in_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIV_W+1] == loaded);
  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (rd_data[DIV_W] || rd_data[DIV_W-1:0] != '0)) |=> !tick);
endmodule

bind prog_tick_div prog_tick_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .rd_data(rd_data), .loaded(loaded), .tick(tick)
);

// File: tb/prog_tick_div_tb.sv
module prog_tick_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_000000, 7'b0_000001, 7'b0_000101, 7'b0_110001,
    7'b1_000000, 7'b1_000010, 7'b1_001100
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic loaded, tick;
  int n_chk = 0, n_fail = 0;

  prog_tick_div u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                       .rd_data(rd_data), .loaded(loaded), .tick(tick));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cycles_to_tick(output int n);
    n = 0;
    while (!tick && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic period(output int n);
    @(negedge clk); n = 1;
    while (!tick && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, p;
    do_reset();
    check(rd_data == 8'h00, "R9 reset read", rd_data, 0);
    check(!tick && !loaded, "R9 reset tick/flag", tick, 0);
    repeat (20) begin
      @(negedge clk);
      if (tick) check(0, "R3 tick while unloaded", 1, 0);
    end
    check(!tick, "R3 idle", tick, 0);

    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      do_write({1'b0, VEC[i]});
      p = (int'(VEC[i][5:0]) + 1) * (VEC[i][6] ? 8 : 1);
      check(rd_data == {1'b1, VEC[i]}, "R1 readback", rd_data, {1'b1, VEC[i]});
      cycles_to_tick(n);
      check(n == p - 1, "R8 first tick", n + 1, p);
      period(n);
      check(n == p, VEC[i][6] ? "R6 period" : "R5 period", n, p);
      if (p > 1) begin
        @(negedge clk);
        check(!tick, "R7 one cycle", tick, 0);
      end
    end

    do_reset();
    do_write(8'h80);
    check(rd_data == 8'h80 && loaded, "R2 write of zero settings", rd_data, 8'h80);
    @(negedge clk);
    check(tick, "R5 div0 every cycle", tick, 1);

    do_reset();
    do_write(8'h03);
    check(loaded && rd_data[7], "R2 flag set by first write", rd_data, 8'h83);
    do_write(8'h7F);
    check(rd_data == 8'h83, "R4 second write ignored", rd_data, 8'h83);
    cycles_to_tick(n);
    period(n);
    check(n == 4, "R4 period unchanged", n, 4);

    do_reset();
    check(rd_data == 8'h00 && !loaded, "R2 reset clears flag", rd_data, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule